// File: doc/BRIEF.md
# Configurable Decimating Down-Converter

This block takes a stream of real 16-bit signed converter samples, one per cycle at most, qualified by a valid strobe. It returns a stream at the same rate (pass-through), at half the rate, or at a quarter of the rate. Each rate change removes samples only after a short fixed half-band anti-alias filter has run on them. At half rate, the caller picks the lower or the upper half of the band. The upper half is folded down by flipping the sign of every odd-indexed sample before the filter. At quarter rate, a mixer stage ahead of two cascaded half-band stages moves one of four band centres down to DC. The mixer uses only sign flips and zeroing, so it needs no multipliers.

The configuration (`mode_i`, `hp_i`, `shift_i`) is set while reset is held and then kept constant. Reset restarts the sample index that the mixer patterns and the decimation phases use. Idle cycles (valid low) advance nothing.

Top module: `ddc_decim`

## Requirements
- R1: While and right after reset, before any sample is accepted, `vld_o` is 0 and `data_o` is 0.
- R2: With `mode_i` = 0 (pass-through), every accepted sample appears on `data_o` with `vld_o` high exactly one cycle later, unchanged.
- R3: With `mode_i` = 1 (half rate), `vld_o` pulses one cycle after the 2nd, 4th, 6th, ... accepted sample since reset and is low in every other cycle.
- R4: A half-band stage output is round((-x[n] + 9x[n-2] + 16x[n-3] + 9x[n-4] - x[n-6]) / 32) computed at each even-counted input n (x = 0 before reset release), with rounding as adding 16 and shifting right arithmetically by 5.
- R5: With `mode_i` = 1 and `hp_i` = 1, samples with odd index n (n counted from 0 after reset) are negated before filtering; negating -32768 gives +32767. With `hp_i` = 0 no sample is changed.
- R6: With `mode_i` = 2 (quarter rate), the output of a first half-band stage feeds a second identical stage; `vld_o` pulses two cycles after the 4th, 8th, 12th, ... accepted sample.
- R7: In quarter-rate mode the mixer weights sample n by w[n mod 4]: `shift_i` = 0 gives {1,1,1,1}, 1 gives {1,0,-1,0}, 2 gives {0,1,0,-1}, 3 gives {1,-1,1,-1}; `hp_i` has no effect in this mode and `shift_i` has none outside it.
- R8: Each filter output saturates to the 16-bit signed range [-32768, 32767] after rounding.
- R9: Cycles with `vld_i` low advance neither the sample index nor any decimation phase and produce no output.
- R10: `mode_i` = 3 behaves exactly as pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 pass-through, 1 half rate, 2 quarter rate, 3 pass-through |
| hp_i | input | 1 | Half rate: 1 selects the upper half band |
| shift_i | input | 2 | Quarter rate: mixer pattern select |
| vld_i | input | 1 | Input sample valid |
| data_i | input | 16 | Input sample, signed |
| vld_o | output | 1 | Output sample valid |
| data_o | output | 16 | Output sample, signed |

## Verification
A pass-through result is due one cycle after its input is accepted. A half-rate result is due one cycle after the second accepted sample of each pair. A quarter-rate result is due two cycles after the fourth accepted sample of each group of four, because it passes through two registered filter stages. The bench runs a reference model at the falling edge on which it drives each sample. The model places every expected result into a one- or two-slot schedule, and the valid and data outputs are compared against the slot that falls due at each later falling edge. An early, late or extra pulse therefore fails, the same as a wrong value.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_DIV2 = 2'd1,
    MODE_DIV4 = 2'd2,
    MODE_RSVD = 2'd3
  } ddc_mode_e;

  typedef enum logic [1:0] {
    W_POS  = 2'd0,
    W_ZERO = 2'd1,
    W_NEG  = 2'd2
  } mix_w_e;

  localparam int HB_TAPS  = 7;
  localparam int HB_SHIFT = 5;
  localparam int HB_GUARD = 6;

  function automatic int hb_coef(input int k);
    case (k)
      0, 6:    return -1;
      2, 4:    return 9;
      3:       return 16;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/ddc_mixer.sv
module ddc_mixer
  import ddc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic                 hp_i,
  input  logic [1:0]           shift_i,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] data_i,
  output logic signed [DW-1:0] data_o
);
  localparam logic signed [DW-1:0] MAX_V = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};

  logic [1:0] idx_q;
  mix_w_e     w;
  ddc_mode_e  mode;

  assign mode = ddc_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (vld_i) idx_q <= idx_q + 2'd1;
  end

  always_comb begin
    w = W_POS;
    if (mode == MODE_DIV2) begin
      w = (hp_i && idx_q[0]) ? W_NEG : W_POS;
    end else if (mode == MODE_DIV4) begin
      case (shift_i)
        2'd1:    w = idx_q[0] ? W_ZERO : (idx_q[1] ? W_NEG : W_POS);
        2'd2:    w = !idx_q[0] ? W_ZERO : (idx_q[1] ? W_NEG : W_POS);
        2'd3:    w = idx_q[0] ? W_NEG : W_POS;
        default: w = W_POS;
      endcase
    end
  end

  always_comb begin
    case (w)
      W_ZERO:  data_o = '0;
      W_NEG:   data_o = (data_i == MIN_V) ? MAX_V : -data_i;
      default: data_o = data_i;
    endcase
  end

  // R5: odd-index sample with high-pass selected must not pass unchanged unless zero
  a_r5_odd_flipped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_DIV2 && hp_i && idx_q[0] && vld_i && data_i > 0) |-> (data_o < 0));
endmodule

// File: rtl/ddc_halfband.sv
module ddc_halfband
  import ddc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] data_i,
  output logic                 vld_o,
  output logic signed [DW-1:0] data_o
);
  localparam int AW = DW + HB_GUARD;
  localparam logic signed [AW-1:0] SAT_HI = AW'((1 <<< (DW-1)) - 1);
  localparam logic signed [AW-1:0] SAT_LO = -SAT_HI - AW'(1);
  localparam logic signed [AW-1:0] HALF   = AW'(1 <<< (HB_SHIFT-1));

  logic signed [DW-1:0] tap_q [HB_TAPS-1];
  logic signed [DW-1:0] win   [HB_TAPS];
  logic signed [AW-1:0] acc, rnd;
  logic signed [DW-1:0] y_sat;
  logic                 phase_q;

  assign win[0] = data_i;
  for (genvar k = 1; k < HB_TAPS; k++) begin : g_win
    assign win[k] = tap_q[k-1];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < HB_TAPS; k++) begin
      acc = acc + AW'(win[k]) * AW'(hb_coef(k));
    end
    rnd = (acc + HALF) >>> HB_SHIFT;
    if (rnd > SAT_HI)      y_sat = SAT_HI[DW-1:0];
    else if (rnd < SAT_LO) y_sat = SAT_LO[DW-1:0];
    else                   y_sat = rnd[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < HB_TAPS-1; k++) tap_q[k] <= '0;
      phase_q <= 1'b0;
      vld_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      vld_o <= vld_i && phase_q;
      if (vld_i) begin
        tap_q[0] <= data_i;
        for (int k = 1; k < HB_TAPS-1; k++) tap_q[k] <= tap_q[k-1];
        phase_q <= ~phase_q;
        if (phase_q) data_o <= y_sat;
      end
    end
  end

  // R3: a decimated stream never yields two results in consecutive cycles
  a_r3_spaced_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
endmodule

// File: rtl/ddc_decim.sv
module ddc_decim
  import ddc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic                 hp_i,
  input  logic [1:0]           shift_i,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] data_i,
  output logic                 vld_o,
  output logic signed [DW-1:0] data_o
);
  ddc_mode_e            mode;
  logic signed [DW-1:0] mix_d;
  logic                 s1_vld, s2_vld, byp_vld_q;
  logic signed [DW-1:0] s1_d, s2_d, byp_d_q;

  assign mode = ddc_mode_e'(mode_i);

  ddc_mixer #(.DW(DW)) u_mix (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .hp_i    (hp_i),
    .shift_i (shift_i),
    .vld_i   (vld_i),
    .data_i  (data_i),
    .data_o  (mix_d)
  );

  ddc_halfband #(.DW(DW)) u_hb1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (vld_i),
    .data_i (mix_d),
    .vld_o  (s1_vld),
    .data_o (s1_d)
  );

  ddc_halfband #(.DW(DW)) u_hb2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s1_vld),
    .data_i (s1_d),
    .vld_o  (s2_vld),
    .data_o (s2_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_vld_q <= 1'b0;
      byp_d_q   <= '0;
    end else begin
      byp_vld_q <= vld_i;
      if (vld_i) byp_d_q <= data_i;
    end
  end

  always_comb begin
    case (mode)
      MODE_DIV2: begin vld_o = s1_vld;    data_o = s1_d;    end
      MODE_DIV4: begin vld_o = s2_vld;    data_o = s2_d;    end
      default:   begin vld_o = byp_vld_q; data_o = byp_d_q; end
    endcase
  end

  // R2 / R10: pass-through is a single register stage
  a_r2_pass_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == MODE_PASS || mode == MODE_RSVD) && vld_i) |=> (vld_o && data_o == $past(data_i)));

  // R3: a half-rate result always follows an accepted sample by one cycle
  a_r3_half_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_DIV2 && vld_o) |-> $past(vld_i));

  // R6: a quarter-rate result trails its last input by two cycles
  a_r6_quarter_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_DIV4 && vld_o) |-> $past(vld_i, 2));
endmodule

// File: tb/tb_ddc_decim.sv
module tb_ddc_decim;
  localparam int DW = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           mode = 2'd0;
  logic                 hp = 1'b0;
  logic [1:0]           shift = 2'd0;
  logic                 vld_in = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic                 vld_out;
  logic signed [DW-1:0] dout;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int h1 [7];
  int h2 [7];
  bit ph1, ph2;
  int idx, acc_cnt;
  bit ev [2];
  int ed [2];

  always #2 clk = ~clk;

  ddc_decim #(.DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .hp_i(hp), .shift_i(shift),
    .vld_i(vld_in), .data_i(din), .vld_o(vld_out), .data_o(dout)
  );

  function automatic int coef(input int k);
    case (k)
      0, 6:    return -1;
      2, 4:    return 9;
      3:       return 16;
      default: return 0;
    endcase
  endfunction

  function automatic int hb_calc(input int a [7]);
    int s = 0;
    int r;
    for (int k = 0; k < 7; k++) s += coef(k) * a[k];
    r = (s + 16) >>> 5;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int neg(input int x);
    return (x == -32768) ? 32767 : -x;
  endfunction

  function automatic int mix_ref(input int x, input int md, input bit h, input int sh, input int n);
    int p = n % 4;
    if (md == 1) return (h && (n % 2 == 1)) ? neg(x) : x;
    case (sh)
      1:       return (p == 0) ? x : (p == 2) ? neg(x) : 0;
      2:       return (p == 1) ? x : (p == 3) ? neg(x) : 0;
      3:       return (n % 2 == 1) ? neg(x) : x;
      default: return x;
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic model_step(input int x, input int md, input bit h, input int sh);
    int m, y;
    if (md == 0 || md == 3) begin
      ev[0] = 1; ed[0] = x;
      return;
    end
    m = mix_ref(x, md, h, sh, idx);
    idx++;
    for (int k = 6; k > 0; k--) h1[k] = h1[k-1];
    h1[0] = m;
    if (ph1) begin
      y = hb_calc(h1);
      if (md == 1) begin
        ev[0] = 1; ed[0] = y;
      end else begin
        for (int k = 6; k > 0; k--) h2[k] = h2[k-1];
        h2[0] = y;
        if (ph2) begin ev[1] = 1; ed[1] = hb_calc(h2); end
        ph2 = ~ph2;
      end
    end
    ph1 = ~ph1;
  endtask

  function automatic int gen(input int kind, input int a);
    case (kind)
      1:       return (a % 6 == 5) ? -32768 : 32767;
      2:       return -32768;
      3:       return ($urandom % 2) ? 32767 : -32768;
      4:       return (a % 6 == 5) ? 32767 : -32768;
      default: return int'($urandom & 32'hFFFF) - 32768;
    endcase
  endfunction

  task automatic run_case(input string tag, input int md, input bit h, input int sh,
                          input int cnt, input int gap_pct, input int kind);
    int x;
    @(negedge clk);
    rst_n = 1'b0; vld_in = 1'b0; din = '0;
    mode = md[1:0]; hp = h; shift = sh[1:0];
    for (int k = 0; k < 7; k++) begin h1[k] = 0; h2[k] = 0; end
    ph1 = 0; ph2 = 0; idx = 0; acc_cnt = 0;
    ev[0] = 0; ev[1] = 0; ed[0] = 0; ed[1] = 0;
    @(negedge clk);
    check("R1", int'(vld_out), 0, "valid in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(vld_out), 0, "valid after reset");
    check("R1", int'(dout), 0, "data after reset");
    for (int i = 0; i < cnt + 4; i++) begin
      @(negedge clk);
      check(tag, int'(vld_out), int'(ev[0]), "valid");
      if (ev[0] && vld_out) check(tag, int'(dout), ed[0], "data");
      ev[0] = ev[1]; ed[0] = ed[1]; ev[1] = 0;
      if (i < cnt && int'($urandom % 100) >= gap_pct) begin
        x = gen(kind, acc_cnt);
        acc_cnt++;
        vld_in = 1'b1; din = DW'(x);
        model_step(x, md, h, sh);
      end else begin
        vld_in = 1'b0;
        din = DW'(int'($urandom & 32'hFFFF));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    run_case("R2",  0, 0, 0, 200, 30, 0);
    run_case("R10", 3, 1, 2, 100, 20, 0);
    run_case("R4",  1, 0, 0, 300, 0,  0);
    run_case("R3",  1, 0, 3, 300, 40, 0);
    run_case("R5",  1, 1, 0, 300, 10, 0);
    run_case("R5",  1, 1, 0, 40,  0,  2);
    run_case("R8",  1, 0, 0, 60,  0,  1);
    run_case("R8",  1, 0, 0, 60,  0,  4);
    run_case("R8",  1, 1, 0, 200, 0,  3);
    run_case("R6",  2, 0, 0, 400, 0,  0);
    run_case("R7",  2, 1, 1, 400, 10, 0);
    run_case("R7",  2, 0, 2, 400, 10, 0);
    run_case("R7",  2, 1, 3, 400, 10, 0);
    run_case("R9",  2, 0, 1, 400, 60, 0);
    run_case("R8",  2, 0, 0, 120, 0,  1);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule